// File: doc/BRIEF.md
# Programmable-Order CIC Decimator

This block turns a one-bit sigma-delta bit stream into multi-bit samples. Each accepted bit counts as +1 (bit high) or -1 (bit low) and feeds a chain of integrators. Once per decimation period a comb chain takes the difference, and the result is scaled by an arithmetic right shift. It is then delivered either sign-extended at full precision or saturated to a 16-bit signed range. The filter order can be set to one, two or three. A fourth setting runs a third-order filter that delivers from the first period.

A restart clears all filter state. Restart happens while the block is disabled and whenever the order or ratio setting changes. After a restart the block drops the outputs that the filter pipeline has not yet settled. It can also drop a programmable number of further outputs. A sticky flag records that a delivered sample saturated, and a one-cycle clear pulse resets it.

Top module: `cic_decim`

## Requirements
- R1: With order code 0, 1 or 2 (K = 1, 2, 3) and a constant input, the settled output equals R^K for all-ones input and -R^K for all-zeros input. An input alternating 1,0 settles to 0 for even R, and a repeating 1,1,1,0 pattern settles to (R/2)^1 for K = 1.
- R2: One output is computed for every R accepted bits, where R is the ratio input; a ratio code of 0 means R = 256.
- R3: Order code 3 runs a third-order filter and delivers from the first period after restart; for all-ones input at R = 4 the first outputs are 20, 60, 64.
- R4: With order codes 0, 1, 2 the first K-1 outputs after a restart are dropped, so a third-order run at R = 4 over four periods delivers two samples, the first being 64.
- R5: The skip input N (0..7) drops N further outputs after restart; with K = 1, N = 3, ten periods deliver seven samples.
- R6: The filter result is shifted right arithmetically by the shift input (0..15), rounding toward minus infinity (-5 shifted by 1 gives -3).
- R7: With wide = 0 the output is clamped to -32768..32767 and sign-extended to 32 bits. With wide = 1 it is the full 26-bit result sign-extended, and never clamped.
- R8: sat_err goes high when a delivered sample is clamped and stays high, across unclamped samples, until a sat_clr pulse; a new clamp in the same cycle wins over the clear.
- R9: While enable is low, and in the cycle order_sel or ratio changes, all filter state is cleared, incoming bits are ignored and no output is delivered; a fresh run then behaves as after reset.
- R10: After reset out_valid, out_data and sat_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run; low holds the filter in restart |
| order_sel | input | 2 | 0/1/2 = order 1/2/3, 3 = fast third order |
| ratio | input | 8 | Decimation ratio, 0 means 256 |
| shift | input | 4 | Arithmetic right shift of the result |
| wide | input | 1 | 1 = 32-bit output, 0 = clamp to 16 bits |
| skip_n | input | 3 | Extra outputs dropped after restart |
| sat_clr | input | 1 | Clear pulse for sat_err |
| bit_valid | input | 1 | Strobe for bit_in |
| bit_in | input | 1 | Modulator bit |
| out_data | output | 32 | Scaled sample, signed |
| out_valid | output | 1 | One-cycle strobe for out_data |
| sat_err | output | 1 | Sticky saturation flag |

## Verification
The filter is driven with constant ones, constant zeros, alternating bits and a three-of-four pattern. Constant inputs separate the gain of each order and the sign handling. The alternating pattern shows that a zero-mean input settles to zero. The three-of-four pattern shows the mean being tracked rather than a bit count. The first delivered values after a restart are compared with the closed-form transient of a zero-state filter, which tells a real clear from leftover state and the fast setting from the normal fill drop. Shift and clamp cases sit on both sides of the 16-bit limits.

// File: rtl/cic_pkg.sv
// Shared encodings for the CIC decimator.
// Assumes the order field is two bits wide.
package cic_pkg;

    typedef enum logic [1:0] {
        ORD_ONE   = 2'd0,
        ORD_TWO   = 2'd1,
        ORD_THREE = 2'd2,
        ORD_FAST  = 2'd3
    } cic_order_e;

    // Index of the last active stage (order minus one).
    function automatic logic [1:0] last_stage(input cic_order_e ord);
        return (ord == ORD_FAST) ? 2'd2 : ord;
    endfunction

    // Outputs to drop while the comb chain fills.
    function automatic logic [1:0] fill_len(input cic_order_e ord);
        return (ord == ORD_FAST) ? 2'd0 : ord;
    endfunction

endpackage

// File: rtl/cic_integ.sv
// Integrator cascade. Each accepted bit adds +1/-1 to stage 0, and each
// later stage adds the new value of the stage before it in the same cycle.
// Assumes wrap-around arithmetic; the comb difference recovers the result.
module cic_integ #(
    parameter int ACC_W = 26,
    parameter int N_STG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    input  logic             bit_in,
    input  logic [1:0]       sel,
    output logic [ACC_W-1:0] stage_out
);
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum [N_STG];

    assign step = bit_in ? ACC_W'(1) : '1;

    for (genvar k = 0; k < N_STG; k++) begin : g_stage
        logic [ACC_W-1:0] acc_r;
        logic [ACC_W-1:0] feed;
        if (k == 0) begin : g_first
            assign feed = step;
        end else begin : g_next
            assign feed = sum[k-1];
        end
        assign sum[k] = acc_r + feed;

        // Accumulate on each accepted bit, clear on restart.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) acc_r <= '0;
            else if (stb)      acc_r <= sum[k];
        end
    end

    assign stage_out = sum[sel];
endmodule

// File: rtl/cic_comb.sv
// Comb cascade run once per decimation period. Each stage subtracts its
// previous input; all delays start at zero after a clear.
module cic_comb #(
    parameter int ACC_W = 26,
    parameter int N_STG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  logic [ACC_W-1:0] din,
    input  logic [1:0]       sel,
    output logic [ACC_W-1:0] dout
);
    logic [ACC_W-1:0] dif [N_STG];

    for (genvar k = 0; k < N_STG; k++) begin : g_stage
        logic [ACC_W-1:0] dly_r;
        logic [ACC_W-1:0] src;
        if (k == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = dif[k-1];
        end
        assign dif[k] = src - dly_r;

        // Hold the previous stage input for the next period.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) dly_r <= '0;
            else if (go)       dly_r <= src;
        end
    end

    assign dout = dif[sel];
endmodule

// File: rtl/cic_scale.sv
// Arithmetic right shift followed by optional clamp to the narrow range.
// Assumes OUT_W >= ACC_W so the wide result never needs clamping.
module cic_scale #(
    parameter int ACC_W    = 26,
    parameter int SHIFT_W  = 4,
    parameter int NARROW_W = 16,
    parameter int OUT_W    = 32
) (
    input  logic [ACC_W-1:0]   din,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               wide,
    output logic [OUT_W-1:0]   dout,
    output logic               sat
);
    localparam logic [ACC_W-1:0] NMAX = ACC_W'((64'd1 << (NARROW_W-1)) - 64'd1);
    localparam logic [ACC_W-1:0] NMIN = ~NMAX;

    logic signed [ACC_W-1:0] shd;
    logic [ACC_W-1:0]        res;
    logic                    fits;

    // Shift, test the narrow range and pick the clamped value.
    always_comb begin
        shd  = $signed(din) >>> shift;
        fits = (&shd[ACC_W-1:NARROW_W-1]) | ~(|shd[ACC_W-1:NARROW_W-1]);
        sat  = !wide && !fits;
        if (sat) res = shd[ACC_W-1] ? NMIN : NMAX;
        else     res = shd;
        dout = {{(OUT_W-ACC_W){res[ACC_W-1]}}, res};
    end
endmodule

// File: rtl/cic_decim.sv
// Programmable-order CIC decimator top. Counts accepted bits into periods,
// runs integrators and combs, scales the result and drops the samples that
// come before the filter settles plus a programmable number more.
// Assumes the configuration is quasi-static; order or ratio changes restart.
module cic_decim
    import cic_pkg::*;
#(
    parameter int RATIO_W  = 8,
    parameter int MAX_ORD  = 3,
    parameter int SHIFT_W  = 4,
    parameter int SKIP_W   = 3,
    parameter int NARROW_W = 16,
    parameter int OUT_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         order_sel,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               wide,
    input  logic [SKIP_W-1:0]  skip_n,
    input  logic               sat_clr,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_valid,
    output logic               sat_err
);
    localparam int ACC_W  = MAX_ORD * RATIO_W + 2;
    localparam int DROP_W = SKIP_W + 1;

    cic_order_e         ord;
    logic [1:0]         ord_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               restart, stb, tick, go, keep;
    logic [RATIO_W:0]   rfull, rfull_q;
    logic [RATIO_W-1:0] cnt;
    logic [1:0]         sel;
    logic [ACC_W-1:0]   integ_out, dec_val, comb_out;
    logic               dec_go;
    logic [DROP_W-1:0]  drop_cnt;
    logic [OUT_W-1:0]   scaled;
    logic               sat_now, wide_q;

    assign ord     = cic_order_e'(order_sel);
    assign sel     = last_stage(ord);
    assign restart = !enable || (order_sel != ord_q) || (ratio != ratio_q);
    assign stb     = bit_valid && !restart;
    assign rfull   = (ratio == '0) ? (RATIO_W+1)'(1 << RATIO_W) : {1'b0, ratio};
    assign rfull_q = (ratio_q == '0) ? (RATIO_W+1)'(1 << RATIO_W) : {1'b0, ratio_q};
    assign tick    = stb && ({1'b0, cnt} == rfull - 1'b1);
    assign go      = dec_go && !restart;
    assign keep    = (drop_cnt == '0);

    // Remember the configuration so a change can be seen next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_q   <= '0;
            ratio_q <= '0;
        end else begin
            ord_q   <= order_sel;
            ratio_q <= ratio;
        end
    end

    // Count accepted bits within the current decimation period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (stb)          cnt <= tick ? '0 : cnt + 1'b1;
    end

    cic_integ #(.ACC_W(ACC_W), .N_STG(MAX_ORD)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(restart), .stb(stb),
        .bit_in(bit_in), .sel(sel), .stage_out(integ_out)
    );

    // Capture the last integrator at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            dec_val <= '0;
            dec_go  <= 1'b0;
        end else begin
            dec_go <= tick;
            if (tick) dec_val <= integ_out;
        end
    end

    cic_comb #(.ACC_W(ACC_W), .N_STG(MAX_ORD)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(restart), .go(go),
        .din(dec_val), .sel(sel), .dout(comb_out)
    );

    cic_scale #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_scale (
        .din(comb_out), .shift(shift), .wide(wide), .dout(scaled), .sat(sat_now)
    );

    // Drop counter: loaded on restart, counts down once per comb result.
    always_ff @(posedge clk) begin
        if (!rst_n)             drop_cnt <= '0;
        else if (restart)       drop_cnt <= DROP_W'(fill_len(ord)) + DROP_W'(skip_n);
        else if (go && !keep)   drop_cnt <= drop_cnt - 1'b1;
    end

    // Output register and sticky saturation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            wide_q    <= 1'b0;
            sat_err   <= 1'b0;
        end else begin
            out_valid <= go && keep;
            if (go && keep) begin
                out_data <= scaled;
                wide_q   <= wide;
            end
            sat_err <= (go && keep && sat_now) || (sat_err && !sat_clr);
        end
    end

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !out_valid);                                          // R9
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_err && !sat_clr) |=> sat_err);                               // R8
    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide_q) |-> ((&out_data[OUT_W-1:NARROW_W-1]) || !(|out_data[OUT_W-1:NARROW_W-1]))); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < rfull_q));                                         // R2
    AST_DROP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(drop_cnt) == '0));                           // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !sat_err));                             // R10
endmodule

// File: tb/cic_decim_test.sv
module cic_decim_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  ord;
        logic [7:0]  ratio;
        logic [3:0]  sh;
        logic        wide;
        logic [1:0]  pat;   // 0 ones, 1 zeros, 2 alternating, 3 three-of-four
        logic [31:0] exp;
        logic        sat;
    } row_t;

    localparam int NROW = 14;
    localparam row_t VEC [0:NROW-1] = '{
        '{2'd0, 8'd8,   4'd0,  1'b1, 2'd0, 32'd8,          1'b0},  // R1
        '{2'd1, 8'd8,   4'd0,  1'b1, 2'd1, 32'hFFFF_FFC0,  1'b0},  // R1
        '{2'd2, 8'd16,  4'd0,  1'b1, 2'd0, 32'd4096,       1'b0},  // R1
        '{2'd2, 8'd16,  4'd0,  1'b1, 2'd2, 32'd0,          1'b0},  // R1
        '{2'd0, 8'd16,  4'd0,  1'b1, 2'd3, 32'd8,          1'b0},  // R1
        '{2'd2, 8'd64,  4'd0,  1'b0, 2'd0, 32'd32767,      1'b1},  // R7
        '{2'd2, 8'd64,  4'd4,  1'b0, 2'd0, 32'd16384,      1'b0},  // R6
        '{2'd2, 8'd64,  4'd3,  1'b0, 2'd1, 32'hFFFF_8000,  1'b0},  // R7
        '{2'd2, 8'd64,  4'd3,  1'b0, 2'd0, 32'd32767,      1'b1},  // R7
        '{2'd2, 8'd64,  4'd0,  1'b1, 2'd0, 32'd262144,     1'b0},  // R7
        '{2'd0, 8'd0,   4'd0,  1'b1, 2'd0, 32'd256,        1'b0},  // R2
        '{2'd2, 8'd0,   4'd15, 1'b1, 2'd0, 32'd512,        1'b0},  // R2
        '{2'd3, 8'd16,  4'd0,  1'b1, 2'd1, 32'hFFFF_F000,  1'b0},  // R3
        '{2'd0, 8'd5,   4'd1,  1'b1, 2'd1, 32'hFFFF_FFFD,  1'b0}   // R6
    };

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, wide = 1'b1;
    logic [1:0] order_sel = '0;
    logic [7:0] ratio = 8'd4;
    logic [3:0] shift = '0;
    logic [2:0] skip_n = '0;
    logic sat_clr = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
    logic [31:0] out_data;
    logic out_valid, sat_err;

    int vectors = 0, fails = 0, n_out = 0, base = 0;
    logic [31:0] outs [0:1023];

    cic_decim uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .order_sel(order_sel),
        .ratio(ratio), .shift(shift), .wide(wide), .skip_n(skip_n),
        .sat_clr(sat_clr), .bit_valid(bit_valid), .bit_in(bit_in),
        .out_data(out_data), .out_valid(out_valid), .sat_err(sat_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            outs[n_out % 1024] = out_data;
            n_out = n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic pat_bit(input logic [1:0] p, input int i);
        case (p)
            2'd0:    return 1'b1;
            2'd1:    return 1'b0;
            2'd2:    return (i % 2) == 0;
            default: return (i % 4) != 3;
        endcase
    endfunction

    task automatic setup(input logic [1:0] o, input logic [7:0] r, input logic [3:0] s,
                         input logic w, input logic [2:0] k);
        @(negedge clk);
        enable = 1'b0; order_sel = o; ratio = r; shift = s; wide = w; skip_n = k;
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0; enable = 1'b1;
        @(negedge clk);
        base = n_out;
    endtask

    task automatic feed(input logic [1:0] p, input int n);
        for (int i = 0; i < n; i++) begin
            bit_valid = 1'b1; bit_in = pat_bit(p, i);
            @(negedge clk);
        end
        bit_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] got(input int idx);
        return outs[idx % 1024];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!out_valid && !sat_err && out_data == 0, "R10 reset", {out_valid, sat_err}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NROW; v++) begin
            int k, rf;
            k  = (VEC[v].ord == 2'd0) ? 1 : (VEC[v].ord == 2'd1) ? 2 : 3;
            rf = (VEC[v].ratio == 0) ? 256 : int'(VEC[v].ratio);
            setup(VEC[v].ord, VEC[v].ratio, VEC[v].sh, VEC[v].wide, 3'd0);
            feed(VEC[v].pat, (k + 2) * rf);
            chk(n_out > base && got(n_out - 1) == VEC[v].exp, $sformatf("R1 row %0d value", v),
                $signed(got(n_out - 1)), $signed(VEC[v].exp));
            chk(sat_err == VEC[v].sat, $sformatf("R8 row %0d flag", v), sat_err, VEC[v].sat);
        end

        // R2: ratio code 0 gives one output per 256 bits
        setup(2'd0, 8'd0, 4'd0, 1'b1, 3'd0);
        feed(2'd0, 3 * 256 + 100);
        chk(n_out - base == 3, "R2 count ratio 0", n_out - base, 3);

        // R3: fast third order delivers from first period
        setup(2'd3, 8'd4, 4'd0, 1'b1, 3'd0);
        feed(2'd0, 16);
        chk(n_out - base == 4, "R3 count", n_out - base, 4);
        chk(got(base) == 20, "R3 first", got(base), 20);
        chk(got(base + 1) == 60, "R3 second", got(base + 1), 60);
        chk(got(base + 2) == 64, "R3 third", got(base + 2), 64);

        // R4: normal third order drops two fill outputs
        setup(2'd2, 8'd4, 4'd0, 1'b1, 3'd0);
        feed(2'd0, 16);
        chk(n_out - base == 2, "R4 count", n_out - base, 2);
        chk(got(base) == 64, "R4 first", got(base), 64);

        // R5: skip three further outputs
        setup(2'd0, 8'd8, 4'd0, 1'b1, 3'd3);
        feed(2'd0, 80);
        chk(n_out - base == 7, "R5 count", n_out - base, 7);

        // R8: flag survives unclamped samples, then clears on pulse
        setup(2'd2, 8'd64, 4'd0, 1'b0, 3'd0);
        feed(2'd0, 4 * 64);
        chk(sat_err == 1'b1, "R8 set", sat_err, 1);
        shift = 4'd4;
        base = n_out;
        feed(2'd0, 2 * 64);
        chk(n_out > base && got(n_out - 1) == 16384, "R8 unclamped value", got(n_out - 1), 16384);
        chk(sat_err == 1'b1, "R8 sticky", sat_err, 1);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        @(negedge clk);
        chk(sat_err == 1'b0, "R8 cleared", sat_err, 0);

        // R9: order change mid-stream restarts from zero state
        setup(2'd0, 8'd4, 4'd0, 1'b1, 3'd0);
        feed(2'd0, 22);
        order_sel = 2'd3;
        @(negedge clk);
        @(negedge clk);
        base = n_out;
        feed(2'd0, 16);
        chk(n_out - base == 4 && got(base) == 20, "R9 order change", got(base), 20);

        // R9: ratio change mid-stream restarts from zero state
        setup(2'd3, 8'd8, 4'd0, 1'b1, 3'd0);
        feed(2'd0, 27);
        ratio = 8'd4;
        @(negedge clk);
        @(negedge clk);
        base = n_out;
        feed(2'd0, 8);
        chk(n_out - base == 2 && got(base) == 20, "R9 ratio change", got(base), 20);

        // R9: bits ignored while disabled
        @(negedge clk);
        enable = 1'b0;
        base = n_out;
        feed(2'd0, 40);
        chk(n_out == base, "R9 disabled", n_out - base, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule